// File: doc/BRIEF.md
# Debug Register Target with Four-Phase Handshake

This block is the target end of a small debug access bus. A debug bridge raises a request line and, in the same cycle, presents an 8-bit address, a write-enable and 64 bits of write data. The target takes in that request on the first clock edge that sees it, performs the access, and answers with an acknowledge. The acknowledge and the read data then stay unchanged for as long as the bridge holds the request high. When the bridge lowers the request, the target lowers the acknowledge one clock later. The bridge then waits at least one more clock before it starts the next access.

Two registers are decoded, each at its own parameterised address. One is a control word that software can read and write; it comes out of reset holding 4 (binary 100, which stands for a terminated state). The other is a read-only status word that always returns 0xDEADBEEF. An access to any other address is acknowledged and does nothing. A write also returns data: the addressed register's contents from before the write.

Top module: `dbg_reg_target`

## Requirements
- R1: While `rst_n` is low at a clock edge, `ack` is 0 after that edge and the control register returns to 4. A later read of address 0 returns 4.
- R2: When `req` is sampled high while `ack` is low, `ack` is 1 after that same edge.
- R3: While `req` stays high, `ack` stays 1 and `rdata` keeps the value it took when the access was accepted.
- R4: When `req` is sampled low while `ack` is high, `ack` is 0 after that edge.
- R5: A write to the control address (default 0) stores `wdata`. A later read of that address returns the stored value.
- R6: A read of the status address (default 1) returns 0x00000000DEADBEEF.
- R7: A write to the status address is acknowledged and changes nothing. A later read still returns 0xDEADBEEF.
- R8: An access to any other address is acknowledged. A read returns 0, and a write leaves the control register unchanged.
- R9: During a write, `rdata` carries what the addressed register held before the write: the old control value, the status constant, or 0 for an unmapped address.
- R10: `addr`, `we` and `wdata` are sampled only on the edge that accepts the request. Changes to them while `req` stays high have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Request from the bridge, held high for the whole access |
| we | input | 1 | 1 = write, 0 = read; valid with the rising `req` |
| addr | input | ADDR_W (8) | Register address; valid with the rising `req` |
| wdata | input | DATA_W (64) | Write data; valid with the rising `req` |
| ack | output | 1 | Acknowledge; held high until one clock after `req` falls |
| rdata | output | DATA_W (64) | Read data; stable while `ack` is high |

## Verification
The assertions assume the bridge follows the protocol. It raises `req` only while `ack` is low, and it keeps `req` low for at least one clock after it sees `ack` fall, so `!ack && req` always marks a fresh access. The stimulus task drives each access that way: it raises `req`, holds it for three clocks, lowers it, and then leaves one extra idle clock before the next access. While `req` is held, the task deliberately scrambles `addr`, `we` and `wdata`. This stays inside the protocol assumption and exercises R10.

// File: rtl/dbgt_pkg.sv
// Package: shared types for the debug register target.
// Assumes: nothing beyond the default bus widths used by the top module.
package dbgt_pkg;

    // Handshake phases: waiting for a request, or holding the acknowledge
    typedef enum logic [0:0] {
        HS_IDLE = 1'b0,
        HS_HOLD = 1'b1
    } hs_state_t;

    // Number of decoded register slots
    localparam int NUM_SLOTS = 2;
    localparam int SLOT_CTRL = 0;
    localparam int SLOT_STAT = 1;

endpackage

// File: rtl/dbgt_decode.sv
// Module: dbgt_decode
// Turns the bus address into a one-hot slot-hit vector. Both slot
// addresses are parameters. Assumes the two addresses differ; no hit
// bit is set for an unmapped address.
module dbgt_decode
    import dbgt_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
    parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(1)
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_SLOTS-1:0] hit
);

    localparam logic [ADDR_W-1:0] SLOT_ADDR [NUM_SLOTS] = '{CTRL_ADDR, STAT_ADDR};

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        // compare the address with one slot
        always_comb hit[s] = (addr == SLOT_ADDR[s]);
    end

endmodule

// File: rtl/dbgt_regs.sv
// Module: dbgt_regs
// Holds the control word and selects read data by slot. The read value
// is combinational and shows the stored word before any write in the
// same cycle. Assumes wr_stb lasts one cycle per accepted write.
module dbgt_regs
    import dbgt_pkg::*;
#(
    parameter int                DATA_W   = 64,
    parameter logic [DATA_W-1:0] CTRL_RST = DATA_W'(4),
    parameter logic [DATA_W-1:0] STAT_VAL = DATA_W'(64'hDEAD_BEEF)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_stb,
    input  logic [NUM_SLOTS-1:0] hit,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rd_val
);

    logic [DATA_W-1:0] ctrl_q;

    // control word storage; the status slot has no storage
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= CTRL_RST;
        else if (wr_stb && hit[SLOT_CTRL])
            ctrl_q <= wdata;
    end

    // read selection, zero for unmapped addresses
    always_comb begin
        rd_val = '0;
        if (hit[SLOT_CTRL])
            rd_val = ctrl_q;
        else if (hit[SLOT_STAT])
            rd_val = STAT_VAL;
    end

endmodule

// File: rtl/dbgt_handshake.sv
// Module: dbgt_handshake
// Four-phase request/acknowledge sequencer. It accepts a request on the
// first edge that sees req high in the idle phase, latches the read
// value and holds ack until req is seen low. Assumes the master keeps
// req low for one clock after ack falls.
module dbgt_handshake
    import dbgt_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [DATA_W-1:0] rd_val,
    output logic              wr_stb,
    output logic              ack,
    output logic [DATA_W-1:0] rdata
);

    hs_state_t         state_q;
    logic [DATA_W-1:0] rdata_q;
    logic              accept;

    // a new access starts only in the idle phase
    always_comb accept = (state_q == HS_IDLE) && req;

    // the write strobe is a single cycle, tied to acceptance
    always_comb wr_stb = accept && we;

    // phase register: go to hold on accept, back to idle once req is seen low
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= HS_IDLE;
        else if (accept)
            state_q <= HS_HOLD;
        else if (state_q == HS_HOLD && !req)
            state_q <= HS_IDLE;
    end

    // read data is captured on accept and kept until the next accept
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (accept)
            rdata_q <= rd_val;
    end

    // outputs come straight from the registers
    always_comb begin
        ack   = (state_q == HS_HOLD);
        rdata = rdata_q;
    end

endmodule

// File: rtl/dbg_reg_target.sv
// Module: dbg_reg_target
// Debug register target on a level-held request/acknowledge bus: one
// read/write control word, one read-only status constant, and every
// other address acknowledged with no effect. Assumes the bridge drives
// addr, we and wdata valid with the rising req.
module dbg_reg_target
    import dbgt_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 64,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
    parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(1),
    parameter logic [DATA_W-1:0] CTRL_RST  = DATA_W'(4),
    parameter logic [DATA_W-1:0] STAT_VAL  = DATA_W'(64'hDEAD_BEEF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata
);

    logic [NUM_SLOTS-1:0] hit;
    logic [DATA_W-1:0]    rd_val;
    logic                 wr_stb;

    dbgt_decode #(
        .ADDR_W   (ADDR_W),
        .CTRL_ADDR(CTRL_ADDR),
        .STAT_ADDR(STAT_ADDR)
    ) u_decode (
        .addr(addr),
        .hit (hit)
    );

    dbgt_regs #(
        .DATA_W  (DATA_W),
        .CTRL_RST(CTRL_RST),
        .STAT_VAL(STAT_VAL)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_stb(wr_stb),
        .hit   (hit),
        .wdata (wdata),
        .rd_val(rd_val)
    );

    dbgt_handshake #(
        .DATA_W(DATA_W)
    ) u_hs (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .we    (we),
        .rd_val(rd_val),
        .wr_stb(wr_stb),
        .ack   (ack),
        .rdata (rdata)
    );

endmodule

// File: rtl/dbg_reg_target_chk.sv
// Module: dbg_reg_target_chk
// Protocol and content checks on the target's ports. Assumes the bridge
// raises req only while ack is low.
module dbg_reg_target_chk #(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 64,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
    parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(1),
    parameter logic [DATA_W-1:0] STAT_VAL  = DATA_W'(64'hDEAD_BEEF)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic              ack,
    input logic [DATA_W-1:0] rdata
);

    // R2: a fresh request is acknowledged after one edge
    a_r2_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack && req) |=> ack);

    // R3: the acknowledge is held while the request is held
    a_r3_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && req) |=> ack);

    // R3: read data stays put while the request is held
    a_r3_rdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && req) |=> $stable(rdata));

    // R4: the acknowledge drops one edge after the request is seen low
    a_r4_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !req) |=> !ack);

    // R6: a status read returns the constant
    a_r6_stat_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack && req && !we && addr == STAT_ADDR) |=> (rdata == STAT_VAL));

    // R8: an unmapped read returns zero
    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack && req && !we && addr != STAT_ADDR && addr != CTRL_ADDR)
        |=> (rdata == '0));

endmodule

bind dbg_reg_target dbg_reg_target_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CTRL_ADDR(CTRL_ADDR),
    .STAT_ADDR(STAT_ADDR),
    .STAT_VAL (STAT_VAL)
) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (req),
    .we   (we),
    .addr (addr),
    .ack  (ack),
    .rdata(rdata)
);

// File: tb/dbg_reg_target_bench.sv
module dbg_reg_target_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [63:0] wdata = '0;
    logic        ack;
    logic [63:0] rdata;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;  // 250 MHz

    dbg_reg_target u_dbg_reg_target (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (req),
        .we   (we),
        .addr (addr),
        .wdata(wdata),
        .ack  (ack),
        .rdata(rdata)
    );

    localparam int NV = 11;
    localparam logic        V_WE   [NV] = '{0, 1, 0, 0, 1, 0, 1, 0, 0, 1, 0};
    localparam logic [7:0]  V_ADDR [NV] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01,
                                            8'h7F, 8'h7F, 8'h00, 8'h00, 8'h00};
    localparam logic [63:0] V_WDAT [NV] = '{64'h0, 64'h5, 64'h0, 64'h0, 64'h1234, 64'h0,
                                            64'hAAAA, 64'h0, 64'h0, '1, 64'h0};
    localparam logic [63:0] V_EXP  [NV] = '{64'h4, 64'h4, 64'h5, 64'hDEADBEEF,
                                            64'hDEADBEEF, 64'hDEADBEEF, 64'h0, 64'h0,
                                            64'h5, 64'h5, '1};
    localparam string       V_TAG  [NV] = '{"R1", "R9", "R5", "R6", "R7", "R7",
                                            "R8", "R8", "R8", "R9", "R5"};

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One full access; inputs are scrambled while req is held (R10)
    task automatic txn(input logic w, input logic [7:0] a, input logic [63:0] d,
                       input logic [63:0] exp, input string tag);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        @(negedge clk);
        chk(ack == 1'b1, "R2", 64'(ack), 64'd1);
        chk(rdata == exp, tag, rdata, exp);
        we = ~w; addr = ~a; wdata = ~d;
        repeat (2) @(negedge clk);
        chk(ack == 1'b1 && rdata == exp, "R3", rdata, exp);
        req = 1'b0;
        @(negedge clk);
        chk(ack == 1'b0, "R4", 64'(ack), 64'd0);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(ack == 1'b0, "R1", 64'(ack), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ack == 1'b0, "R1", 64'(ack), 64'd0);

        for (int i = 0; i < NV; i++)
            txn(V_WE[i], V_ADDR[i], V_WDAT[i], V_EXP[i], V_TAG[i]);

        // R10: a write of 0x11 to control; scrambled inputs must not land
        txn(1'b1, 8'h00, 64'h11, '1, "R9");
        txn(1'b0, 8'h00, 64'h0, 64'h11, "R10");
        txn(1'b0, 8'h01, 64'h0, 64'hDEADBEEF, "R10");

        // R1: reset in the middle of an access
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = 8'h00; wdata = 64'h77;
        @(negedge clk);
        chk(ack == 1'b1, "R2", 64'(ack), 64'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(ack == 1'b0, "R1", 64'(ack), 64'd0);
        req = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        txn(1'b0, 8'h00, 64'h0, 64'h4, "R1");

        // R8: a write to an unmapped address leaves control alone
        txn(1'b1, 8'hFE, 64'hBAD, 64'h0, "R8");
        txn(1'b0, 8'h00, 64'h0, 64'h4, "R8");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 5000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule